// File: doc/BRIEF.md
# Pixel-to-Planar Tile Row Converter

This block converts one band of a four-band pixel store into planar two-bit-per-pixel tile data. A band holds eight lines of 160 pixels, and each pixel is two bits wide. A pixel producer fills the band store through its own write port.

A host write to the control offset picks one band. The choice depends on the written value, a snapshotted display row and a line counter. The same write rewinds the host read pointer and starts the conversion. The conversion handles one pixel per clock and produces 320 bytes in tile order. The host then reads those bytes one at a time from the data offset, and the pointer advances after each read.

While a conversion runs, the block reports busy. Reads of the data offset during that time return zero and leave the pointer where it is.

Top module: `tile_plane_packer`

## Requirements
- R1: The band store holds 4 bands. Pixel x (0..159) of line y (0..7) in band b is written through the producer port at index y*160+x with band number b. A later producer write changes that pixel's contribution to the next conversion.
- R2: A host write with `host_addr` = 0x6001 selects band (row - (4 - (value - ly))) mod 4. Here row is `lcd_row`, ly is `line_ctr` and value is `host_wdata`.
- R3: For the pixel at line y and column x, bit 0 of the pixel lands in output byte y*2 + (x/8)*16, and bit 1 lands in the byte after it.
- R4: Within an output byte, the pixel at column x occupies bit 7 - (x mod 8), so the leftmost pixel is the MSB.
- R5: Each conversion replaces all 320 output bytes, and no content from an earlier band survives it.
- R6: A write at offset 0x6001 sets the read pointer to 0. `busy` reads 1 in the cycle after the write.
- R7: A read with `host_addr` = 0x7800 while idle returns, in the following cycle on `host_rdata`, the byte at the pointer. The pointer then advances and wraps from 319 to 0.
- R8: After a control write, `busy` stays high for exactly 1281 cycles and then falls.
- R9: A data read while `busy` is high returns 0x00 and does not move the pointer.
- R10: After reset, `busy` is 0 and a data read returns 0x00.
- R11: Reads at any offset other than 0x7800 return 0x00 and do not move the pointer. Writes at any offset other than 0x6001 start nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pix_we | input | 1 | Producer pixel write strobe |
| pix_band | input | 2 | Band number for the producer write |
| pix_idx | input | 11 | Pixel index y*160+x inside the band |
| pix_data | input | 2 | Pixel value |
| lcd_row | input | 8 | Snapshotted display row |
| line_ctr | input | 8 | Current line counter |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe |
| host_addr | input | 16 | Host offset |
| host_wdata | input | 8 | Host write value |
| host_rdata | output | 8 | Host read data, valid the cycle after the read |
| busy | output | 1 | Conversion in progress |

## Verification
A wrong tile counter or line counter writes a whole byte pair to the wrong slot. The full 320-byte readback after each conversion exposes that as soon as the affected byte is reached. A wrong band selection changes nearly every byte of the readback. A bit-order error in the shift registers corrupts every byte. A wrong pointer shows within one read, either at the wrap from 319 to 0 or at the first read after a rewind. A wrong busy length is caught within one conversion by counting busy cycles.

// File: rtl/tpc_pkg.sv
// Shared definitions for the tile row converter.
// Assumes the band count is four, since band selection works modulo four.
package tpc_pkg;

    // Computes which band a control write selects. Only the low two bits of
    // the result matter, and modulo-256 arithmetic keeps them correct.
    function automatic logic [1:0] pick_band(input logic [7:0] row,
                                             input logic [7:0] val,
                                             input logic [7:0] ly);
        return 2'(row - (8'd4 - (val - ly)));
    endfunction

endpackage

// File: rtl/tpc_band_ram.sv
// Band store: a single-port-write, single-port-read synchronous RAM.
// The read data appears one cycle after the address is presented.
// Assumes the writer and the reader never need to be ordered within a cycle.
module tpc_band_ram #(
    parameter int DEPTH = 5120,
    parameter int DW    = 2,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    logic [DW-1:0] mem [DEPTH];

    // Store producer pixels.
    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    // Registered read for the conversion sequencer.
    always_ff @(posedge clk) begin
        rdata <= mem[raddr];
    end
endmodule

// File: rtl/tpc_scan_seq.sv
// Conversion sequencer: walks one band in tile order. The column inside a
// tile is the innermost count, then the line, then the tile. It issues one
// read address per clock and carries a tag one stage further, aligned with
// the RAM read data. Assumes WIDTH is a multiple of 8.
module tpc_scan_seq #(
    parameter int LINES = 8,
    parameter int WIDTH = 160,
    parameter int BANDS = 4,
    localparam int TILES = WIDTH / 8,
    localparam int PIX   = LINES * WIDTH,
    localparam int AW    = $clog2(BANDS * PIX),
    localparam int WIW   = $clog2(TILES * LINES),
    localparam int BW    = $clog2(BANDS),
    localparam int YW    = $clog2(LINES),
    localparam int TW    = $clog2(TILES)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start,
    input  logic [BW-1:0]  band_in,
    output logic [AW-1:0]  rd_addr,
    output logic           s1_valid,
    output logic           s1_last,
    output logic [WIW-1:0] s1_widx,
    output logic           busy
);
    logic          active;
    logic [BW-1:0] band_q;
    logic [2:0]    c_q;
    logic [YW-1:0] y_q;
    logic [TW-1:0] t_q;
    logic          c_end, y_end, t_end;

    assign c_end = (c_q == 3'd7);
    assign y_end = (y_q == YW'(LINES - 1));
    assign t_end = (t_q == TW'(TILES - 1));

    // Walk column, then line, then tile; stop after the final pixel.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active <= 1'b0;
            band_q <= '0;
            c_q    <= '0;
            y_q    <= '0;
            t_q    <= '0;
        end else if (start) begin
            active <= 1'b1;
            band_q <= band_in;
            c_q    <= '0;
            y_q    <= '0;
            t_q    <= '0;
        end else if (active) begin
            c_q <= c_q + 3'd1;
            if (c_end) begin
                if (y_end) begin
                    y_q <= '0;
                    if (t_end) active <= 1'b0;
                    else       t_q <= t_q + TW'(1);
                end else begin
                    y_q <= y_q + YW'(1);
                end
            end
        end
    end

    assign rd_addr = AW'(band_q) * AW'(PIX) + AW'(y_q) * AW'(WIDTH)
                   + AW'(t_q) * AW'(8) + AW'(c_q);

    // Delay the tag by one stage so it lines up with the RAM output.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_valid <= 1'b0;
            s1_last  <= 1'b0;
            s1_widx  <= '0;
        end else begin
            s1_valid <= active && !start;
            s1_last  <= c_end;
            s1_widx  <= WIW'(t_q) * WIW'(LINES) + WIW'(y_q);
        end
    end

    assign busy = active | s1_valid;
endmodule

// File: rtl/tpc_plane_pack.sv
// Bit-plane packer: shifts eight consecutive pixels into two plane bytes,
// with the first pixel ending up in the MSB. On the eighth pixel it emits
// both bytes as one word: plane 0 in the low byte, plane 1 in the high byte.
module tpc_plane_pack #(
    parameter int WIW = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           in_valid,
    input  logic           in_last,
    input  logic [WIW-1:0] in_widx,
    input  logic [1:0]     in_pix,
    output logic           wr_en,
    output logic [WIW-1:0] wr_idx,
    output logic [15:0]    wr_word
);
    logic [7:0] p0_q, p1_q, p0_n, p1_n;

    assign p0_n = {p0_q[6:0], in_pix[0]};
    assign p1_n = {p1_q[6:0], in_pix[1]};

    // Shift one pixel into each plane register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            p0_q <= '0;
            p1_q <= '0;
        end else if (in_valid) begin
            p0_q <= p0_n;
            p1_q <= p1_n;
        end
    end

    assign wr_en   = in_valid && in_last;
    assign wr_idx  = in_widx;
    assign wr_word = {p1_n, p0_n};
endmodule

// File: rtl/tpc_out_buf.sv
// Output buffer and host read pointer. Bytes are stored as plane-pair words;
// byte i lives in word i/2, with the low byte holding the even index.
// Assumes clear and a word write never need to land in the same cycle.
module tpc_out_buf #(
    parameter int WORDS = 160,
    localparam int BYTES = 2 * WORDS,
    localparam int WIW   = $clog2(WORDS),
    localparam int PW    = $clog2(BYTES)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           clear,
    input  logic           wr_en,
    input  logic [WIW-1:0] wr_idx,
    input  logic [15:0]    wr_word,
    input  logic           fetch,
    input  logic           zero_rd,
    output logic [7:0]     rdata,
    output logic [PW-1:0]  rd_ptr
);
    logic [15:0] words [WORDS];
    logic [15:0] cur_word;

    assign cur_word = words[rd_ptr[PW-1:1]];

    // Clear on a new conversion, otherwise accept packed word pairs.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            for (int i = 0; i < WORDS; i++) words[i] <= '0;
        end else if (wr_en) begin
            words[wr_idx] <= wr_word;
        end
    end

    // Rewind, or step and wrap, the host read pointer.
    always_ff @(posedge clk) begin
        if (!rst_n || clear)  rd_ptr <= '0;
        else if (fetch)       rd_ptr <= (rd_ptr == PW'(BYTES - 1)) ? '0 : rd_ptr + PW'(1);
    end

    // Register the byte returned to the host.
    always_ff @(posedge clk) begin
        if (!rst_n)       rdata <= '0;
        else if (fetch)   rdata <= rd_ptr[0] ? cur_word[15:8] : cur_word[7:0];
        else if (zero_rd) rdata <= '0;
    end
endmodule

// File: rtl/tile_plane_packer.sv
// Top: decodes host accesses, picks the band and ties together the band
// store, sequencer, packer and output buffer.
// Assumes the host does not raise read and write in the same cycle; if it
// does, the write wins and the read is dropped.
module tile_plane_packer #(
    parameter int          LINES     = 8,
    parameter int          WIDTH     = 160,
    parameter int          BANDS     = 4,
    parameter logic [15:0] CTRL_ADDR = 16'h6001,
    parameter logic [15:0] DATA_ADDR = 16'h7800
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              pix_we,
    input  logic [$clog2(BANDS)-1:0]          pix_band,
    input  logic [$clog2(LINES*WIDTH)-1:0]    pix_idx,
    input  logic [1:0]                        pix_data,
    input  logic [7:0]                        lcd_row,
    input  logic [7:0]                        line_ctr,
    input  logic                              host_wr,
    input  logic                              host_rd,
    input  logic [15:0]                       host_addr,
    input  logic [7:0]                        host_wdata,
    output logic [7:0]                        host_rdata,
    output logic                              busy
);
    import tpc_pkg::*;

    localparam int PIX   = LINES * WIDTH;
    localparam int WORDS = (WIDTH / 8) * LINES;
    localparam int BYTES = 2 * WORDS;
    localparam int AW    = $clog2(BANDS * PIX);
    localparam int WIW   = $clog2(WORDS);
    localparam int PW    = $clog2(BYTES);
    localparam int BW    = $clog2(BANDS);

    logic           ctrl_hit, data_rd, fetch, zero_rd;
    logic [BW-1:0]  band_sel;
    logic [AW-1:0]  ram_waddr, ram_raddr;
    logic [1:0]     ram_rdata;
    logic           s1_valid, s1_last;
    logic [WIW-1:0] s1_widx, wr_idx;
    logic           wr_en;
    logic [15:0]    wr_word;
    logic [PW-1:0]  rd_ptr_w;

    assign ctrl_hit  = host_wr && (host_addr == CTRL_ADDR);
    assign data_rd   = host_rd && !host_wr && (host_addr == DATA_ADDR);
    assign fetch     = data_rd && !busy;
    assign zero_rd   = host_rd && !fetch;
    assign band_sel  = BW'(pick_band(lcd_row, host_wdata, line_ctr));
    assign ram_waddr = AW'(pix_band) * AW'(PIX) + AW'(pix_idx);

    tpc_band_ram #(.DEPTH(BANDS * PIX), .DW(2)) u_ram (
        .clk(clk), .we(pix_we), .waddr(ram_waddr), .wdata(pix_data),
        .raddr(ram_raddr), .rdata(ram_rdata)
    );

    tpc_scan_seq #(.LINES(LINES), .WIDTH(WIDTH), .BANDS(BANDS)) u_seq (
        .clk(clk), .rst_n(rst_n), .start(ctrl_hit), .band_in(band_sel),
        .rd_addr(ram_raddr), .s1_valid(s1_valid), .s1_last(s1_last),
        .s1_widx(s1_widx), .busy(busy)
    );

    tpc_plane_pack #(.WIW(WIW)) u_pack (
        .clk(clk), .rst_n(rst_n), .in_valid(s1_valid), .in_last(s1_last),
        .in_widx(s1_widx), .in_pix(ram_rdata), .wr_en(wr_en),
        .wr_idx(wr_idx), .wr_word(wr_word)
    );

    tpc_out_buf #(.WORDS(WORDS)) u_obuf (
        .clk(clk), .rst_n(rst_n), .clear(ctrl_hit), .wr_en(wr_en),
        .wr_idx(wr_idx), .wr_word(wr_word), .fetch(fetch),
        .zero_rd(zero_rd), .rdata(host_rdata), .rd_ptr(rd_ptr_w)
    );
endmodule

// File: rtl/tile_plane_packer_chk.sv
// Checker for the host-visible protocol of tile_plane_packer.
// Assumes it is bound with the top's parameters and its internal read pointer.
module tile_plane_packer_chk #(
    parameter logic [15:0] CTRL_ADDR = 16'h6001,
    parameter logic [15:0] DATA_ADDR = 16'h7800,
    parameter int          BYTES     = 320,
    parameter int          RUN_CYC   = 1281,
    parameter int          PW        = 9
) (
    input logic          clk,
    input logic          rst_n,
    input logic          host_wr,
    input logic          host_rd,
    input logic [15:0]   host_addr,
    input logic [7:0]    host_rdata,
    input logic          busy,
    input logic [PW-1:0] rd_ptr
);
    logic [15:0] run_cnt;

    // Count busy cycles since the latest control write.
    always_ff @(posedge clk) begin
        if (!rst_n)                                    run_cnt <= '0;
        else if (host_wr && host_addr == CTRL_ADDR)    run_cnt <= '0;
        else if (busy)                                 run_cnt <= run_cnt + 16'd1;
        else                                           run_cnt <= '0;
    end

    // R6
    start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        host_wr && host_addr == CTRL_ADDR |=> busy);
    // R6
    start_rewind_chk: assert property (@(posedge clk) disable iff (!rst_n)
        host_wr && host_addr == CTRL_ADDR |=> rd_ptr == '0);
    // R7
    ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        host_rd && !host_wr && host_addr == DATA_ADDR && !busy |=>
        rd_ptr == (($past(rd_ptr) == PW'(BYTES - 1)) ? '0 : $past(rd_ptr) + PW'(1)));
    // R7
    ptr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_ptr < PW'(BYTES));
    // R9
    busy_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        host_rd && !host_wr && busy |=> host_rdata == 8'h00 && $stable(rd_ptr));
    // R11
    other_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        host_rd && !host_wr && host_addr != DATA_ADDR |=> host_rdata == 8'h00 && $stable(rd_ptr));
    // R8
    run_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        run_cnt <= 16'(RUN_CYC));
endmodule

bind tile_plane_packer tile_plane_packer_chk #(
    .CTRL_ADDR(CTRL_ADDR), .DATA_ADDR(DATA_ADDR), .BYTES(BYTES),
    .RUN_CYC(PIX + 1), .PW(PW)
) u_chk (
    .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_rd(host_rd),
    .host_addr(host_addr), .host_rdata(host_rdata), .busy(busy),
    .rd_ptr(rd_ptr_w)
);

// File: tb/sim_tile_plane_packer.sv
module sim_tile_plane_packer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pix_we = 1'b0;
    logic [1:0]  pix_band = '0;
    logic [10:0] pix_idx = '0;
    logic [1:0]  pix_data = '0;
    logic [7:0]  lcd_row = '0, line_ctr = '0;
    logic        host_wr = 1'b0, host_rd = 1'b0;
    logic [15:0] host_addr = '0;
    logic [7:0]  host_wdata = '0;
    logic [7:0]  host_rdata;
    logic        busy;

    int n_chk = 0, n_bad = 0;
    bit done = 1'b0;
    logic [1:0] model [4][1280];

    always #4 clk = ~clk;

    tile_plane_packer u0 (
        .clk(clk), .rst_n(rst_n), .pix_we(pix_we), .pix_band(pix_band),
        .pix_idx(pix_idx), .pix_data(pix_data), .lcd_row(lcd_row),
        .line_ctr(line_ctr), .host_wr(host_wr), .host_rd(host_rd),
        .host_addr(host_addr), .host_wdata(host_wdata),
        .host_rdata(host_rdata), .busy(busy)
    );

    // value, row, ly, expected band = (row + value - ly) mod 4
    localparam int VEC [6][4] = '{
        '{0, 0, 0, 0}, '{1, 0, 0, 1}, '{3, 2, 1, 0},
        '{2, 1, 3, 0}, '{5, 7, 6, 2}, '{0, 3, 2, 1}
    };

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_byte(input int band, input int i);
        int t = i / 16;
        int y = (i % 16) / 2;
        int pl = i % 2;
        logic [7:0] r = '0;
        for (int c = 0; c < 8; c++) r[7 - c] = model[band][y * 160 + t * 8 + c][pl];
        return r;
    endfunction

    task automatic pix_write(input int b, input int idx, input logic [1:0] v);
        pix_we = 1'b1; pix_band = 2'(b); pix_idx = 11'(idx); pix_data = v;
        model[b][idx] = v;
        @(negedge clk);
        pix_we = 1'b0;
    endtask

    task automatic hwrite(input logic [15:0] a, input logic [7:0] v);
        host_wr = 1'b1; host_addr = a; host_wdata = v;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic hread(input logic [15:0] a, output logic [7:0] v);
        host_rd = 1'b1; host_addr = a;
        @(negedge clk);
        host_rd = 1'b0;
        v = host_rdata;
    endtask

    task automatic wait_idle(output int cyc);
        cyc = 0;
        while (busy && cyc < 5000) begin
            cyc++;
            @(negedge clk);
        end
    endtask

    task automatic start_conv(input int val, input int row, input int ly);
        lcd_row = 8'(row); line_ctr = 8'(ly);
        hwrite(16'h6001, 8'(val));
    endtask

    task automatic read_all(input int band, input string tag);
        logic [7:0] v;
        for (int i = 0; i < 320; i++) begin
            hread(16'h7800, v);
            check($sformatf("%s band=%0d byte=%0d", tag, band, i), int'(v), int'(exp_byte(band, i)));
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        int cyc;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10: reset state
        check("R10 busy after reset", int'(busy), 0);
        hread(16'h7800, v);
        check("R10 read after reset", int'(v), 0);

        // R1: fill every band through the producer port
        for (int b = 0; b < 4; b++)
            for (int i = 0; i < 1280; i++)
                pix_write(b, i, 2'((b * 7 + i * 3 + i / 5) % 4));

        // R2 R3 R4 R5 R8: table of band-selection vectors
        for (int k = 0; k < 6; k++) begin
            start_conv(VEC[k][0], VEC[k][1], VEC[k][2]);
            wait_idle(cyc);
            check($sformatf("R8 busy length vec %0d", k), cyc, 1281);
            read_all(VEC[k][3], "R2 R3 R4 R5");
        end

        // R7: pointer wrapped to 0 after 320 reads (last band was 1)
        hread(16'h7800, v);
        check("R7 wrap to byte 0", int'(v), int'(exp_byte(1, 0)));

        // R9: read during conversion returns 0, pointer stays
        start_conv(2, 0, 0);
        repeat (10) @(negedge clk);
        hread(16'h7800, v);
        check("R9 read while busy", int'(v), 0);
        wait_idle(cyc);
        hread(16'h7800, v);
        check("R9 pointer not advanced", int'(v), int'(exp_byte(2, 0)));

        // R11: other offsets ignored
        hread(16'h7801, v);
        check("R11 read other offset", int'(v), 0);
        hwrite(16'h6002, 8'h01);
        check("R11 write other offset no start", int'(busy), 0);
        hread(16'h7800, v);
        check("R11 pointer kept", int'(v), int'(exp_byte(2, 1)));

        // R6: rewind after partial read
        for (int i = 0; i < 4; i++) hread(16'h7800, v);
        start_conv(2, 0, 0);
        check("R6 busy after control write", int'(busy), 1);
        wait_idle(cyc);
        hread(16'h7800, v);
        check("R6 pointer rewound", int'(v), int'(exp_byte(2, 0)));

        // R1: update one pixel (band 3, line 3, column 17) and reconvert
        pix_write(3, 3 * 160 + 17, ~model[3][3 * 160 + 17]);
        start_conv(3, 0, 0);
        wait_idle(cyc);
        for (int i = 0; i < 40; i++) begin
            hread(16'h7800, v);
            if (i == 38 || i == 39)
                check($sformatf("R1 updated pixel byte %0d", i), int'(v), int'(exp_byte(3, i)));
        end

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule